// File: doc/BRIEF.md
# Hot-Plug Slot Command Engine

This block executes the command half of a hot-plug controller. Software writes an 8-bit command code together with a 5-bit slot number, and a single-cycle strobe launches the command. The engine decodes the code. It then updates a set of per-slot fields: the slot state, the power indicator, the attention indicator, the latch-open flag, the presence code and the event bits. It also updates a secondary-bus speed field and a small command status word. Slots are numbered from 1 up to `NSLOTS`, and the parameter may be at most 31.

A slot command packs three fields into one code byte: a requested state, a power indicator setting and an attention indicator setting. The requested state is checked against the slot's current state before it is applied. Two group commands walk every slot, one slot per clock: one powers all slots, the other enables all slots. Taking a slot out of service is reduced to status changes: the latch is marked open, the presence code is set to empty, and three event bits are latched.

The controller runs a four-state machine:
- IDLE waits for a strobe.
- EXEC decodes the code and executes the command.
- WALK visits one slot per clock during a group command.
- DONE clears busy and raises the command-done flag.

The transitions are:
- IDLE to EXEC on an accepted strobe.
- EXEC to WALK for a group command that passes its check.
- EXEC to DONE in every other case.
- WALK to DONE after the last slot.
- DONE to IDLE unconditionally.

Top module: `hp_cmd_engine`

## Requirements
- R1: Synchronous reset (rst_n low at a clock edge) sets up each slot from `card_present`.
  - An occupied slot becomes enabled (state 2) with its power indicator on (1), latch closed and presence code 00.
  - An empty slot becomes disabled (state 3) with its power indicator off (3), latch open and presence code 11.
  - Attention indicators, events, status, speed and the done flag all reset to 0.
- R2: Codes 0x00–0x3F are slot commands. Code bits [1:0] carry the requested state (0 keep, 1 power-only, 2 enabled, 3 disabled). Bits [3:2] carry the power indicator and bits [5:4] the attention indicator, both encoded as 0 keep, 1 on, 2 blink, 3 off.
- R3: A slot number of 0, or one greater than NSLOTS, sets status bit 2 (invalid command) and changes no slot field.
- R4: Moving an enabled slot to power-only is invalid: it sets status bit 2 and changes nothing. A disabled slot may move to power-only or enabled. An enabled or power-only slot may move to disabled. Every other request leaves the state unchanged.
- R5: On a valid slot command, each nonzero indicator field is written to the slot, even when the state does not change.
- R6: If a slot enters disabled and its power indicator then reads off (3), its latch-open bit is set and its presence code becomes 11. Its event bits are also set: bit 0 presence, bit 1 button, bit 2 latch.
- R7: Codes 0x40–0x47 set the bus speed from code bits [2:0]. Only 0 is accepted; any other value sets status bit 3 (invalid mode).
- R8: Code 0x48 (power all) and code 0x49 (enable all) fail with status bit 2 if any slot is enabled. Otherwise each slot is handled by its latch:
  - A slot with its latch closed is requested to power-only or enabled, respectively, with the power indicator on.
  - A slot with its latch open is given the power indicator off and no state request.
- R9: Any code outside 0x00–0x49 sets status bit 2.
- R10: Status bits [3:0] are cleared at the strobe edge, and bit 0 (busy) is set at the same edge.
  - A non-group command, or a group command that fails its check, takes effect at the next edge, and busy clears one edge later.
  - A group command that passes its check updates slot i at edge 2+i after the strobe, and busy clears at edge NSLOTS+2.
  - `cmd_detected` rises at the edge where busy clears.
- R11: A strobe that arrives while busy is set is ignored.
- R12: No command clears a latch-open bit or an event bit. `cmd_detected` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we | input | 1 | One-cycle command launch strobe |
| cmd_code | input | 8 | Command code |
| cmd_slot | input | 5 | Target slot number (1-based) |
| card_present | input | NSLOTS | Slot occupancy sampled during reset |
| slot_state | output | 2*NSLOTS | Per-slot state, slot i at [2i+1:2i] |
| pwr_led | output | 2*NSLOTS | Per-slot power indicator |
| attn_led | output | 2*NSLOTS | Per-slot attention indicator |
| latch_open | output | NSLOTS | Per-slot latch-open flag |
| presence | output | 2*NSLOTS | Per-slot presence code (11 = empty) |
| slot_events | output | 3*NSLOTS | Per-slot event bits, slot i at [3i+2:3i] |
| bus_speed | output | 3 | Secondary bus speed field |
| cmd_status | output | 4 | {invalid mode, invalid cmd, reserved 0, busy} |
| cmd_detected | output | 1 | Command-done flag |

## Verification
The hardest condition to reach from the ports is a group command that passes its check. Reaching it requires that no slot is enabled, yet the reset pattern always enables the occupied slots. The stimulus therefore first takes each enabled slot out of service with single slot commands. It does so with different power indicator values, so that one slot is evicted and another is disabled with its latch still closed. This leaves a mix of open and closed latches for the walk to treat differently. A second strobe is then fired into the middle of the walk to show that it is dropped.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam logic [1:0] ST_KEEP  = 2'd0;
    localparam logic [1:0] ST_PWR   = 2'd1;
    localparam logic [1:0] ST_EN    = 2'd2;
    localparam logic [1:0] ST_DIS   = 2'd3;

    localparam logic [1:0] LED_KEEP  = 2'd0;
    localparam logic [1:0] LED_ON    = 2'd1;
    localparam logic [1:0] LED_BLINK = 2'd2;
    localparam logic [1:0] LED_OFF   = 2'd3;

    localparam logic [7:0] CODE_PWR_ALL = 8'h48;
    localparam logic [7:0] CODE_EN_ALL  = 8'h49;

    typedef enum logic [1:0] {
        FSM_IDLE = 2'd0,
        FSM_EXEC = 2'd1,
        FSM_WALK = 2'd2,
        FSM_DONE = 2'd3
    } fsm_e;
endpackage

// File: rtl/hp_slot_rules.sv
module hp_slot_rules
    import hp_pkg::*;
(
    input  logic [1:0] cur_st,
    input  logic [1:0] cur_pwr,
    input  logic [1:0] cur_attn,
    input  logic [1:0] req_st,
    input  logic [1:0] req_pwr,
    input  logic [1:0] req_attn,
    output logic       illegal,
    output logic [1:0] nx_st,
    output logic [1:0] nx_pwr,
    output logic [1:0] nx_attn,
    output logic       evict
);
    always_comb begin
        illegal = (cur_st == ST_EN) && (req_st == ST_PWR);
        nx_pwr  = (req_pwr  != LED_KEEP) ? req_pwr  : cur_pwr;
        nx_attn = (req_attn != LED_KEEP) ? req_attn : cur_attn;
        nx_st   = cur_st;
        evict   = 1'b0;
        if (cur_st == ST_DIS && (req_st == ST_PWR || req_st == ST_EN)) begin
            nx_st = req_st;
        end else if ((cur_st == ST_EN || cur_st == ST_PWR) && req_st == ST_DIS) begin
            nx_st = ST_DIS;
            evict = (nx_pwr == LED_OFF);
        end
    end
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       occupied,
    input  logic       we,
    input  logic [1:0] nx_st,
    input  logic [1:0] nx_pwr,
    input  logic [1:0] nx_attn,
    input  logic       evict,
    output logic [1:0] st,
    output logic [1:0] pwr,
    output logic [1:0] attn,
    output logic       latch,
    output logic [1:0] prsnt,
    output logic [2:0] evts
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= occupied ? ST_EN  : ST_DIS;
            pwr   <= occupied ? LED_ON : LED_OFF;
            attn  <= LED_KEEP;
            latch <= !occupied;
            prsnt <= occupied ? 2'b00 : 2'b11;
            evts  <= 3'b000;
        end else if (we) begin
            st   <= nx_st;
            pwr  <= nx_pwr;
            attn <= nx_attn;
            if (evict) begin
                latch <= 1'b1;
                prsnt <= 2'b11;
                evts  <= 3'b111;
            end
        end
    end
endmodule

// File: rtl/hp_cmd_engine.sv
module hp_cmd_engine
    import hp_pkg::*;
#(
    parameter int NSLOTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_we,
    input  logic [7:0]            cmd_code,
    input  logic [4:0]            cmd_slot,
    input  logic [NSLOTS-1:0]     card_present,
    output logic [2*NSLOTS-1:0]   slot_state,
    output logic [2*NSLOTS-1:0]   pwr_led,
    output logic [2*NSLOTS-1:0]   attn_led,
    output logic [NSLOTS-1:0]     latch_open,
    output logic [2*NSLOTS-1:0]   presence,
    output logic [3*NSLOTS-1:0]   slot_events,
    output logic [2:0]            bus_speed,
    output logic [3:0]            cmd_status,
    output logic                  cmd_detected
);
    localparam int IDXW = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;
    localparam logic [IDXW-1:0] LAST = IDXW'(NSLOTS - 1);

    fsm_e state_q, state_d;
    logic [7:0]      code_q;
    logic [4:0]      tgt_q;
    logic [4:0]      tgt_m1;
    logic [IDXW-1:0] walk_q;
    logic [IDXW-1:0] sel;
    logic [3:0]      status_q;
    logic [2:0]      speed_q;
    logic            det_q;

    logic [1:0] st_a   [NSLOTS];
    logic [1:0] pwr_a  [NSLOTS];
    logic [1:0] attn_a [NSLOTS];
    logic       latch_a[NSLOTS];

    logic is_slot, is_speed, is_grp, tgt_ok, any_en;
    logic [1:0] req_st, req_pwr, req_attn;
    logic [1:0] nx_st, nx_pwr, nx_attn;
    logic illegal, evict, commit;

    assign is_slot  = (code_q[7:6] == 2'b00);
    assign is_speed = (code_q[7:3] == 5'b01000);
    assign is_grp   = (code_q == CODE_PWR_ALL) || (code_q == CODE_EN_ALL);
    assign tgt_ok   = (tgt_q != 5'd0) && (int'(tgt_q) <= NSLOTS);
    assign tgt_m1   = tgt_q - 5'd1;
    assign sel      = (state_q == FSM_WALK) ? walk_q : tgt_m1[IDXW-1:0];

    always_comb begin
        any_en = 1'b0;
        for (int i = 0; i < NSLOTS; i++) begin
            if (st_a[i] == ST_EN) any_en = 1'b1;
        end
    end

    always_comb begin
        if (state_q == FSM_WALK) begin
            req_attn = LED_KEEP;
            if (!latch_a[sel]) begin
                req_st  = (code_q == CODE_EN_ALL) ? ST_EN : ST_PWR;
                req_pwr = LED_ON;
            end else begin
                req_st  = ST_KEEP;
                req_pwr = LED_OFF;
            end
        end else begin
            req_st   = code_q[1:0];
            req_pwr  = code_q[3:2];
            req_attn = code_q[5:4];
        end
    end

    hp_slot_rules u_rules (
        .cur_st   (st_a[sel]),
        .cur_pwr  (pwr_a[sel]),
        .cur_attn (attn_a[sel]),
        .req_st   (req_st),
        .req_pwr  (req_pwr),
        .req_attn (req_attn),
        .illegal  (illegal),
        .nx_st    (nx_st),
        .nx_pwr   (nx_pwr),
        .nx_attn  (nx_attn),
        .evict    (evict)
    );

    assign commit = (state_q == FSM_WALK) ||
                    (state_q == FSM_EXEC && is_slot && tgt_ok && !illegal);

    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        logic [1:0] prs;
        logic [2:0] ev;
        hp_slot_regs u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .occupied (card_present[g]),
            .we       (commit && (sel == IDXW'(g))),
            .nx_st    (nx_st),
            .nx_pwr   (nx_pwr),
            .nx_attn  (nx_attn),
            .evict    (evict),
            .st       (st_a[g]),
            .pwr      (pwr_a[g]),
            .attn     (attn_a[g]),
            .latch    (latch_a[g]),
            .prsnt    (prs),
            .evts     (ev)
        );
        assign slot_state[2*g +: 2]  = st_a[g];
        assign pwr_led[2*g +: 2]     = pwr_a[g];
        assign attn_led[2*g +: 2]    = attn_a[g];
        assign latch_open[g]         = latch_a[g];
        assign presence[2*g +: 2]    = prs;
        assign slot_events[3*g +: 3] = ev;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FSM_IDLE: if (cmd_we) state_d = FSM_EXEC;
            FSM_EXEC: state_d = (is_grp && !any_en) ? FSM_WALK : FSM_DONE;
            FSM_WALK: if (walk_q == LAST) state_d = FSM_DONE;
            FSM_DONE: state_d = FSM_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FSM_IDLE;
        else        state_q <= state_d;
    end

    // command outputs and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= 8'h00;
            tgt_q    <= 5'd0;
            walk_q   <= '0;
            status_q <= 4'b0000;
            speed_q  <= 3'd0;
            det_q    <= 1'b0;
        end else begin
            unique case (state_q)
                FSM_IDLE: if (cmd_we) begin
                    code_q   <= cmd_code;
                    tgt_q    <= cmd_slot;
                    status_q <= 4'b0001;
                end
                FSM_EXEC: begin
                    walk_q <= '0;
                    if (is_slot) begin
                        if (!tgt_ok || illegal) status_q[2] <= 1'b1;
                    end else if (is_speed) begin
                        if (code_q[2:0] == 3'd0) speed_q <= code_q[2:0];
                        else                     status_q[3] <= 1'b1;
                    end else if (is_grp) begin
                        if (any_en) status_q[2] <= 1'b1;
                    end else begin
                        status_q[2] <= 1'b1;
                    end
                end
                FSM_WALK: walk_q <= walk_q + 1'b1;
                FSM_DONE: begin
                    status_q[0] <= 1'b0;
                    det_q       <= 1'b1;
                end
            endcase
        end
    end

    assign cmd_status   = status_q;
    assign bus_speed    = speed_q;
    assign cmd_detected = det_q;
endmodule

// File: rtl/hp_cmd_engine_chk.sv
module hp_cmd_engine_chk #(
    parameter int NSLOTS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*NSLOTS-1:0] slot_state,
    input logic [2*NSLOTS-1:0] pwr_led,
    input logic [2*NSLOTS-1:0] attn_led,
    input logic [NSLOTS-1:0]   latch_open,
    input logic [3*NSLOTS-1:0] slot_events,
    input logic [2:0]          bus_speed,
    input logic [3:0]          cmd_status,
    input logic                cmd_detected
);
    // R3
    invalid_nochange_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_status[2]) |-> ($stable(slot_state) && $stable(pwr_led) && $stable(attn_led)));

    // R10
    done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_status[0]) |-> cmd_detected);

    // R12
    det_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cmd_detected) |-> cmd_detected);

    // R12
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~latch_open) & $past(latch_open)) == '0);

    // R12
    event_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~slot_events) & $past(slot_events)) == '0);

    // R7
    speed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_speed == 3'd0);
endmodule

bind hp_cmd_engine hp_cmd_engine_chk #(.NSLOTS(NSLOTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_state   (slot_state),
    .pwr_led      (pwr_led),
    .attn_led     (attn_led),
    .latch_open   (latch_open),
    .slot_events  (slot_events),
    .bus_speed    (bus_speed),
    .cmd_status   (cmd_status),
    .cmd_detected (cmd_detected)
);

// File: tb/tb_hp_cmd_engine.sv
module tb_hp_cmd_engine;
    localparam int N = 4;
    localparam int CLK_PERIOD = 10;
    localparam logic [N-1:0] PRESENT = 4'b0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_we = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic [4:0] cmd_slot = 5'd0;
    logic [2*N-1:0] slot_state, pwr_led, attn_led, presence;
    logic [N-1:0]   latch_open;
    logic [3*N-1:0] slot_events;
    logic [2:0] bus_speed;
    logic [3:0] cmd_status;
    logic       cmd_detected;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hp_cmd_engine #(.NSLOTS(N)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
        .cmd_slot(cmd_slot), .card_present(PRESENT),
        .slot_state(slot_state), .pwr_led(pwr_led), .attn_led(attn_led),
        .latch_open(latch_open), .presence(presence), .slot_events(slot_events),
        .bus_speed(bus_speed), .cmd_status(cmd_status), .cmd_detected(cmd_detected)
    );

    // behavioural reference model
    int ms[N], mp[N], ma[N], ml[N], mpr[N], mev[N];
    int mstat, mdet, mspeed, phase, mcode, mtgt, widx;
    bit bad, anyen;

    task automatic m_reset();
        for (int i = 0; i < N; i++) begin
            if (PRESENT[i]) begin ms[i] = 2; mp[i] = 1; ml[i] = 0; mpr[i] = 0; end
            else            begin ms[i] = 3; mp[i] = 3; ml[i] = 1; mpr[i] = 3; end
            ma[i] = 0; mev[i] = 0;
        end
        mstat = 0; mdet = 0; mspeed = 0; phase = 0; widx = 0;
    endtask

    task automatic m_apply(int s, int rq, int pw, int at, output bit b);
        b = 1'b0;
        if (ms[s] == 2 && rq == 1) begin b = 1'b1; return; end
        if (pw != 0) mp[s] = pw;
        if (at != 0) ma[s] = at;
        if (ms[s] == 3 && (rq == 1 || rq == 2)) ms[s] = rq;
        else if ((ms[s] == 2 || ms[s] == 1) && rq == 3) begin
            ms[s] = 3;
            if (mp[s] == 3) begin ml[s] = 1; mpr[s] = 3; mev[s] = 7; end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            case (phase)
                0: if (cmd_we) begin
                    mcode = int'(cmd_code); mtgt = int'(cmd_slot); mstat = 1; phase = 1;
                end
                1: begin
                    phase = 3;
                    if (mcode < 64) begin
                        if (mtgt < 1 || mtgt > N) mstat |= 4;
                        else begin
                            m_apply(mtgt - 1, mcode & 3, (mcode >> 2) & 3, (mcode >> 4) & 3, bad);
                            if (bad) mstat |= 4;
                        end
                    end else if (mcode <= 71) begin
                        if ((mcode & 7) != 0) mstat |= 8; else mspeed = 0;
                    end else if (mcode == 72 || mcode == 73) begin
                        anyen = 1'b0;
                        for (int i = 0; i < N; i++) if (ms[i] == 2) anyen = 1'b1;
                        if (anyen) mstat |= 4;
                        else begin widx = 0; phase = 2; end
                    end else mstat |= 4;
                end
                2: begin
                    if (ml[widx] == 0) m_apply(widx, (mcode == 73) ? 2 : 1, 1, 0, bad);
                    else               m_apply(widx, 0, 3, 0, bad);
                    widx++;
                    if (widx == N) phase = 3;
                end
                default: begin
                    mstat &= ~1; mdet = 1; phase = 0;
                end
            endcase
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [31:0] e_st, e_pw, e_at, e_lt, e_pr, e_ev;
            e_st = 0; e_pw = 0; e_at = 0; e_lt = 0; e_pr = 0; e_ev = 0;
            for (int i = 0; i < N; i++) begin
                e_st |= 32'(ms[i])  << (2*i);
                e_pw |= 32'(mp[i])  << (2*i);
                e_at |= 32'(ma[i])  << (2*i);
                e_lt |= 32'(ml[i])  << i;
                e_pr |= 32'(mpr[i]) << (2*i);
                e_ev |= 32'(mev[i]) << (3*i);
            end
            chk("R4 slot state vs model",      32'(slot_state),  e_st);
            chk("R5 power led vs model",       32'(pwr_led),     e_pw);
            chk("R5 attention led vs model",   32'(attn_led),    e_at);
            chk("R6 latch vs model",           32'(latch_open),  e_lt);
            chk("R6 presence vs model",        32'(presence),    e_pr);
            chk("R6 events vs model",          32'(slot_events), e_ev);
            chk("R10 status vs model",         32'(cmd_status),  32'(mstat));
            chk("R10 detected vs model",       32'(cmd_detected), 32'(mdet));
            chk("R7 bus speed vs model",       32'(bus_speed),   32'(mspeed));
        end
    end

    task automatic send(int c, int s);
        @(negedge clk);
        cmd_we = 1'b1; cmd_code = 8'(c); cmd_slot = 5'(s);
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic settle();
        while (phase != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset image: slots 1 and 3 occupied
        chk("R1 reset slot state", 32'(slot_state), 32'h0000_00EE);
        chk("R1 reset power led",  32'(pwr_led),    32'h0000_00DD);
        chk("R1 reset latch",      32'(latch_open), 32'h0000_000A);
        chk("R1 reset presence",   32'(presence),   32'h0000_00CC);
        chk("R1 reset status",     32'({cmd_detected, cmd_status}), 32'h0);

        // R9 undefined code, with R10 edge timing
        send(8'h80, 1);
        chk("R10 busy after strobe",   32'(cmd_status), 32'h1);
        @(negedge clk);
        chk("R10 result with busy",    32'(cmd_status), 32'h5);
        chk("R10 detected still low",  32'(cmd_detected), 32'h0);
        @(negedge clk);
        chk("R9 invalid code status",  32'(cmd_status), 32'h4);
        chk("R10 detected on finish",  32'(cmd_detected), 32'h1);
        settle();

        // R3 bad targets
        send(8'h0F, 0); settle();
        chk("R3 slot 0 invalid", 32'(cmd_status), 32'h4);
        chk("R3 slot 0 no change", 32'(slot_state), 32'h0000_00EE);
        send(8'h0F, 5); settle();
        chk("R3 slot 5 invalid", 32'(cmd_status), 32'h4);
        send(8'h30, 31); settle();
        chk("R3 slot 31 invalid", 32'(attn_led), 32'h0);

        // R4 enabled to power-only
        send(8'h01, 1); settle();
        chk("R4 en->pwr invalid", 32'(cmd_status), 32'h4);

        // R2 R5 led fields only, then R11 strobe while busy
        send(8'h24, 1);
        send(8'h80, 2);
        settle();
        chk("R11 second strobe ignored", 32'(cmd_status), 32'h0);
        chk("R2 R5 attention blink", 32'(attn_led[1:0]), 32'h2);

        // R6 eviction on disable with led off
        send(8'h0F, 1); settle();
        chk("R6 events latched", 32'(slot_events[2:0]), 32'h7);
        chk("R6 presence empty", 32'(presence[1:0]), 32'h3);
        chk("R6 latch open", 32'(latch_open[0]), 32'h1);

        // R8 group rejected while slot 3 enabled
        send(8'h49, 0); settle();
        chk("R8 enable-all rejected", 32'(cmd_status), 32'h4);

        // R6 disable with blink: no eviction
        send(8'h0B, 3); settle();
        chk("R6 no eviction when led blinks", 32'(latch_open[2]), 32'h0);

        // R8 power-all walk, R11 strobe mid walk
        send(8'h48, 0);
        send(8'h43, 0);
        settle();
        chk("R8 power-all states", 32'(slot_state), 32'h0000_00DF);
        chk("R11 mid-walk strobe ignored", 32'(cmd_status), 32'h0);

        send(8'h49, 0); settle();
        chk("R8 enable-all from power-only", 32'(slot_state), 32'h0000_00DF);

        // R4 power-only request enabled: no rule, then to disabled
        send(8'h02, 3); settle();
        chk("R4 pwr->en unchanged", 32'(slot_state), 32'h0000_00DF);
        send(8'h03, 3); settle();
        chk("R4 pwr->dis", 32'(slot_state), 32'h0000_00FF);

        // R12 re-enable keeps latch and events
        send(8'h06, 1); settle();
        chk("R12 events kept", 32'(slot_events[2:0]), 32'h7);
        chk("R12 latch kept", 32'(latch_open[0]), 32'h1);
        chk("R12 detected kept", 32'(cmd_detected), 32'h1);

        send(8'h48, 0); settle();
        chk("R8 power-all rejected", 32'(cmd_status), 32'h4);

        // R7 speed codes
        send(8'h40, 0); settle();
        chk("R7 speed 0 accepted", 32'(cmd_status), 32'h0);
        send(8'h43, 0); settle();
        chk("R7 speed 3 invalid mode", 32'(cmd_status), 32'h8);

        // R4 R5 illegal request writes no led
        send(8'h1D, 1); settle();
        chk("R4 illegal keeps attention", 32'(attn_led[1:0]), 32'h2);
        // R5 attention written with no state change
        send(8'h33, 3); settle();
        chk("R5 attention off on disabled slot", 32'(attn_led[5:4]), 32'h3);

        summary();
        $finish;
    end
endmodule